// File: doc/BRIEF.md
# Interrupt Message Acceptance Unit

This block sits at the receive side of a local interrupt controller and takes interrupt messages from any source: local, an I/O interrupt controller, or another processor. For each message it first decides whether this node is one of the addressed destinations. A message that is not for this node is dropped with no side effects. A message that is for this node is accepted and steered by its delivery mode. The special modes go directly to a core-side strobe. Ordinary vectored interrupts go to a pending-request strobe that carries the vector. An INIT level de-assert message reloads the arbitration ID register from the node ID.

Delivery can fail when the local sink reports that it is busy. The block then keeps the message and tries it again on each following cycle, up to a configurable number of attempts. After the last attempt it gives up and reports an error. A startup message is never retried. Every attempt produces a status code so that the sender can follow the outcome.

Messages enter over a valid/ready handshake. A message is consumed on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while a held message is waiting for another attempt. While it is low, the payload on the input is ignored and need not be kept stable. The block can always take a new message on the cycle after a message completes. The core, pending and status outputs are registered single-cycle strobes with no back-pressure.

Top module: `irq_accept_unit`

## Requirements
- R1: In physical mode (`in_logical`=0) the message is for this node when `in_dest` equals `local_id` or when `in_dest` is all ones (broadcast).
- R2: In logical mode (`in_logical`=1) the message is for this node when `in_dest` AND `logical_mask` is non-zero.
- R3: A message that is not for this node causes no core or pending strobe and leaves `arb_id` unchanged. In the next cycle the status is DROP (`st_code`=1).
- R4: The reserved delivery mode 3'b011 is discarded in the same way, with status DROP. The other mode codes are Fixed=000, LowestPri=001, SMI=010, NMI=100, INIT=101, StartUp=110 and ExtINT=111.
- R5: An accepted SMI, NMI, INIT (with `in_deassert`=0), ExtINT or StartUp message raises `core_valid` for one cycle in the next cycle, with its mode and vector. It raises no pending strobe.
- R6: An accepted Fixed or LowestPri message raises `pend_valid` for one cycle in the next cycle, with its vector. It raises no core strobe.
- R7: An accepted INIT message with `in_deassert`=1 loads `arb_id` with `local_id` in the next cycle. It raises no core or pending strobe, ignores `sink_busy`, and reports OK (0).
- R8: When an accepted message meets `sink_busy`=1, the block reports RETRY (2), holds the message, drops `in_ready`, and tries the held message again on the following cycle.
- R9: A StartUp message that meets `sink_busy`=1 is never retried. Its status is GIVEUP (3) and `in_ready` stays high.
- R10: After MAX_TRIES failed attempts (default 4) the status is GIVEUP, the message is released, and `in_ready` returns high.
- R11: Each attempt produces exactly one `st_valid` pulse in the cycle after the attempt. A successful delivery reports OK (0).
- R12: After reset all strobes are low, `in_ready` is high and `arb_id` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id | input | 8 | This node's physical ID |
| logical_mask | input | 8 | This node's logical destination mask |
| sink_busy | input | 1 | Local sink cannot take a delivery this cycle |
| in_valid | input | 1 | Message offered |
| in_ready | output | 1 | Block can consume a message |
| in_dest | input | 8 | Destination field |
| in_logical | input | 1 | 1 = logical destination mode |
| in_mode | input | 3 | Delivery mode |
| in_deassert | input | 1 | Level de-assert flag (meaningful for INIT) |
| in_vector | input | 8 | Interrupt vector |
| core_valid | output | 1 | Special-mode strobe to the core |
| core_mode | output | 3 | Mode carried with core_valid |
| core_vector | output | 8 | Vector carried with core_valid |
| pend_valid | output | 1 | Vectored pending-request strobe |
| pend_vector | output | 8 | Vector carried with pend_valid |
| st_valid | output | 1 | Per-attempt status strobe |
| st_code | output | 2 | 0 OK, 1 DROP, 2 RETRY, 3 GIVEUP |
| arb_id | output | 8 | Arbitration ID register |

## Verification
The main function is exercised with physical hits, broadcasts, near-miss IDs, logical masks with one or with no overlapping bits, and every delivery mode including the reserved code. These patterns show an address miss apart from a mode discard and a core route apart from a pending route. Busy windows of different lengths separate a delivery that succeeds on a retry, one that runs out of attempts, and a StartUp message that gives up at once. Throughout the directed and random traffic, a behavioural model predicts every output on every clock. That includes the cycles where `in_ready` is low and the offered payload has to be ignored.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWEST = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_SIPI   = 3'b110,
    DM_EXTINT = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_DROP   = 2'd1,
    ST_RETRY  = 2'd2,
    ST_GIVEUP = 2'd3
  } status_e;
endpackage

// File: rtl/dest_match.sv
module dest_match #(
  parameter int ID_W     = 8,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic [ID_W-1:0] dest,
  input  logic            logical,
  input  logic [ID_W-1:0] local_id,
  input  logic [ID_W-1:0] mask,
  output logic            hit
);
  logic bcast;

  generate
    if (BCAST_EN) begin : g_bcast
      assign bcast = &dest;
    end else begin : g_nobcast
      assign bcast = 1'b0;
    end
  endgenerate

  // R1 physical compare, R2 logical mask overlap
  assign hit = logical ? |(dest & mask) : ((dest == local_id) | bcast);
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import irq_accept_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       deassert,
  output logic       is_rsvd,
  output logic       is_special,
  output logic       is_vectored,
  output logic       is_reload,
  output logic       is_sipi
);
  always_comb begin
    is_rsvd     = 1'b0;
    is_special  = 1'b0;
    is_vectored = 1'b0;
    is_reload   = 1'b0;
    unique case (mode)
      DM_FIXED, DM_LOWEST:             is_vectored = 1'b1;
      DM_RSVD:                         is_rsvd     = 1'b1;
      DM_INIT:                         if (deassert) is_reload = 1'b1;
                                       else          is_special = 1'b1;
      DM_SMI, DM_NMI, DM_SIPI, DM_EXTINT: is_special = 1'b1;
      default:                         is_rsvd     = 1'b1;
    endcase
  end

  assign is_sipi = (mode == DM_SIPI);

  // R4: every mode code falls into exactly one class
  always_comb begin
    if (!$isunknown({mode, deassert}))
      p_class_onehot_r4: assert ($onehot({is_rsvd, is_special, is_vectored, is_reload}));
  end
endmodule

// File: rtl/arb_id_reg.sv
module arb_id_reg #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [ID_W-1:0] local_id,
  output logic [ID_W-1:0] arb_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arb_id <= '0;
    else if (reload) arb_id <= local_id;
  end

  p_arb_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> arb_id == $past(local_id));
  p_arb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(arb_id));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int VEC_W     = 8,
  parameter int MAX_TRIES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  local_id,
  input  logic [ID_W-1:0]  logical_mask,
  input  logic             sink_busy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_dest,
  input  logic             in_logical,
  input  logic [2:0]       in_mode,
  input  logic             in_deassert,
  input  logic [VEC_W-1:0] in_vector,
  output logic             core_valid,
  output logic [2:0]       core_mode,
  output logic [VEC_W-1:0] core_vector,
  output logic             pend_valid,
  output logic [VEC_W-1:0] pend_vector,
  output logic             st_valid,
  output logic [1:0]       st_code,
  output logic [ID_W-1:0]  arb_id
);
  localparam int CNT_W = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(MAX_TRIES - 1);

  // held message for retry
  logic             retry_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0]  hold_dest;
  logic             hold_logical;
  logic [2:0]       hold_mode;
  logic             hold_deassert;
  logic [VEC_W-1:0] hold_vector;

  // current candidate
  logic             cur_valid;
  logic [ID_W-1:0]  cur_dest;
  logic             cur_logical;
  logic [2:0]       cur_mode;
  logic             cur_deassert;
  logic [VEC_W-1:0] cur_vector;

  assign in_ready     = !retry_q;
  assign cur_valid    = retry_q | in_valid;
  assign cur_dest     = retry_q ? hold_dest     : in_dest;
  assign cur_logical  = retry_q ? hold_logical  : in_logical;
  assign cur_mode     = retry_q ? hold_mode     : in_mode;
  assign cur_deassert = retry_q ? hold_deassert : in_deassert;
  assign cur_vector   = retry_q ? hold_vector   : in_vector;

  logic hit, is_rsvd, is_special, is_vectored, is_reload, is_sipi;

  dest_match #(.ID_W(ID_W), .BCAST_EN(1'b1)) u_match (
    .dest     (cur_dest),
    .logical  (cur_logical),
    .local_id (local_id),
    .mask     (logical_mask),
    .hit      (hit)
  );

  mode_decode u_decode (
    .mode        (cur_mode),
    .deassert    (cur_deassert),
    .is_rsvd     (is_rsvd),
    .is_special  (is_special),
    .is_vectored (is_vectored),
    .is_reload   (is_reload),
    .is_sipi     (is_sipi)
  );

  logic acc, fail, retry_d, reload;
  logic [1:0] st_d;

  assign acc     = cur_valid && hit && !is_rsvd;
  assign reload  = acc && is_reload;
  assign fail    = acc && !is_reload && sink_busy;
  assign retry_d = fail && !is_sipi && (cnt_q != LAST_TRY);

  always_comb begin
    st_d = ST_OK;
    if (!acc)                                 st_d = ST_DROP;
    else if (fail && (is_sipi || !retry_d))   st_d = ST_GIVEUP;
    else if (fail)                            st_d = ST_RETRY;
  end

  arb_id_reg #(.ID_W(ID_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .local_id (local_id),
    .arb_id   (arb_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_q       <= 1'b0;
      cnt_q         <= '0;
      hold_dest     <= '0;
      hold_logical  <= 1'b0;
      hold_mode     <= '0;
      hold_deassert <= 1'b0;
      hold_vector   <= '0;
      core_valid    <= 1'b0;
      core_mode     <= '0;
      core_vector   <= '0;
      pend_valid    <= 1'b0;
      pend_vector   <= '0;
      st_valid      <= 1'b0;
      st_code       <= ST_OK;
    end else begin
      retry_q    <= retry_d;
      cnt_q      <= retry_d ? cnt_q + 1'b1 : '0;
      core_valid <= acc && is_special && !sink_busy;
      pend_valid <= acc && is_vectored && !sink_busy;
      st_valid   <= cur_valid;
      if (cur_valid) st_code <= st_d;
      if (acc && is_special) begin
        core_mode   <= cur_mode;
        core_vector <= cur_vector;
      end
      if (acc && is_vectored) pend_vector <= cur_vector;
      if (retry_d) begin
        hold_dest     <= cur_dest;
        hold_logical  <= cur_logical;
        hold_mode     <= cur_mode;
        hold_deassert <= cur_deassert;
        hold_vector   <= cur_vector;
      end
    end
  end

  p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && !hit) |=> (!core_valid && !pend_valid && st_code == ST_DROP));
  p_route_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> !pend_valid);
  p_retry_reported_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_q) |-> (st_valid && st_code == ST_RETRY));
  p_sipi_no_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> hold_mode != DM_SIPI);
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_TRIES));
endmodule

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;
  localparam int MAXT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] local_id, logical_mask;
  logic       sink_busy, in_valid, in_ready;
  logic [7:0] in_dest;
  logic       in_logical, in_deassert;
  logic [2:0] in_mode;
  logic [7:0] in_vector;
  logic       core_valid, pend_valid, st_valid;
  logic [2:0] core_mode;
  logic [7:0] core_vector, pend_vector, arb_id;
  logic [1:0] st_code;

  always #4 clk = ~clk;

  irq_accept_unit dut (
    .clk(clk), .rst_n(rst_n), .local_id(local_id), .logical_mask(logical_mask),
    .sink_busy(sink_busy), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_logical(in_logical), .in_mode(in_mode),
    .in_deassert(in_deassert), .in_vector(in_vector),
    .core_valid(core_valid), .core_mode(core_mode), .core_vector(core_vector),
    .pend_valid(pend_valid), .pend_vector(pend_vector),
    .st_valid(st_valid), .st_code(st_code), .arb_id(arb_id)
  );

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R12";

  // behavioural model state
  bit       m_held = 0;
  int       m_tries = 0;
  logic [7:0] h_dest, h_vec;
  bit       h_log, h_deas;
  logic [2:0] h_mode;
  bit       e_core_v = 0, e_pend_v = 0, e_st_v = 0;
  logic [2:0] e_core_m = 0;
  logic [7:0] e_core_vec = 0, e_pend_vec = 0, e_arb = 0;
  logic [1:0] e_st = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_held = 0; m_tries = 0;
      e_core_v = 0; e_pend_v = 0; e_st_v = 0;
      e_core_m = 0; e_core_vec = 0; e_pend_vec = 0; e_arb = 0; e_st = 0;
    end else begin
      bit v, lg, ds, here, rsv, spec;
      logic [7:0] d, vc;
      logic [2:0] md;
      v  = m_held || in_valid;
      d  = m_held ? h_dest : in_dest;
      lg = m_held ? h_log  : in_logical;
      md = m_held ? h_mode : in_mode;
      ds = m_held ? h_deas : in_deassert;
      vc = m_held ? h_vec  : in_vector;
      e_core_v = 0; e_pend_v = 0; e_st_v = v;
      if (v) begin
        here = lg ? ((d & logical_mask) != 0) : (d == local_id || d == 8'hFF);
        rsv  = (md == 3'b011);
        spec = (md == 3'b010 || md == 3'b100 || md == 3'b110 || md == 3'b111 ||
                (md == 3'b101 && !ds));
        if (!here || rsv) begin
          e_st = 1; m_held = 0; m_tries = 0;
        end else if (md == 3'b101 && ds) begin
          e_arb = local_id; e_st = 0; m_held = 0; m_tries = 0;
        end else if (sink_busy) begin
          if (md == 3'b110 || m_tries + 1 >= MAXT) begin
            e_st = 3; m_held = 0; m_tries = 0;
          end else begin
            e_st = 2; m_held = 1; m_tries++;
            h_dest = d; h_log = lg; h_mode = md; h_deas = ds; h_vec = vc;
          end
        end else begin
          e_st = 0; m_held = 0; m_tries = 0;
          if (spec) begin e_core_v = 1; e_core_m = md; e_core_vec = vc; end
          else begin e_pend_v = 1; e_pend_vec = vc; end
        end
      end
    end
  end

  task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("in_ready", {15'd0, in_ready}, {15'd0, !m_held});
    cmp("core_valid", {15'd0, core_valid}, {15'd0, e_core_v});
    if (e_core_v) begin
      cmp("core_mode", {13'd0, core_mode}, {13'd0, e_core_m});
      cmp("core_vector", {8'd0, core_vector}, {8'd0, e_core_vec});
    end
    cmp("pend_valid", {15'd0, pend_valid}, {15'd0, e_pend_v});
    if (e_pend_v) cmp("pend_vector", {8'd0, pend_vector}, {8'd0, e_pend_vec});
    cmp("st_valid", {15'd0, st_valid}, {15'd0, e_st_v});
    if (e_st_v) cmp("st_code", {14'd0, st_code}, {14'd0, e_st});
    cmp("arb_id", {8'd0, arb_id}, {8'd0, e_arb});
  endtask

  // one clock: compare at negedge, then drive
  task automatic step(bit v, logic [7:0] d, bit lg, logic [2:0] md, bit ds,
                      logic [7:0] vc, bit busy);
    in_valid = v; in_dest = d; in_logical = lg; in_mode = md;
    in_deassert = ds; in_vector = vc; sink_busy = busy;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 3'b000, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; local_id = 8'h2A; logical_mask = 8'h0C;
    in_valid = 0; in_dest = 0; in_logical = 0; in_mode = 0;
    in_deassert = 0; in_vector = 0; sink_busy = 0;
    repeat (3) @(negedge clk);
    cur_tag = "R12"; compare_all();       // reset state
    rst_n = 1;
    idle(2);

    cur_tag = "R1";  step(1, 8'h2A, 0, 3'b000, 0, 8'h31, 0); idle(1);
    cur_tag = "R1";  step(1, 8'hFF, 0, 3'b100, 0, 8'h02, 0); idle(1);
    cur_tag = "R3";  step(1, 8'h2B, 0, 3'b100, 0, 8'h02, 0); idle(1);
    cur_tag = "R2";  step(1, 8'h04, 1, 3'b001, 0, 8'h44, 0); idle(1);
    cur_tag = "R3";  step(1, 8'hF3, 1, 3'b000, 0, 8'h45, 0); idle(1);
    cur_tag = "R4";  step(1, 8'h2A, 0, 3'b011, 0, 8'h46, 0); idle(1);
    cur_tag = "R5";
    step(1, 8'h2A, 0, 3'b010, 0, 8'h10, 0);
    step(1, 8'h2A, 0, 3'b101, 0, 8'h11, 0);
    step(1, 8'h2A, 0, 3'b110, 0, 8'h12, 0);
    step(1, 8'h2A, 0, 3'b111, 0, 8'h13, 0); idle(1);
    cur_tag = "R6";  step(1, 8'h2A, 0, 3'b000, 0, 8'hA5, 0); idle(1);
    cur_tag = "R7";  local_id = 8'h37;
    step(1, 8'hFF, 0, 3'b101, 1, 8'h00, 1); idle(1);
    cur_tag = "R3";  step(1, 8'h2A, 0, 3'b101, 1, 8'h00, 0); idle(1);
    cur_tag = "R8";
    step(1, 8'h37, 0, 3'b000, 0, 8'h77, 1);
    step(1, 8'h99, 0, 3'b100, 0, 8'h88, 1);   // offered while blocked
    step(1, 8'h99, 0, 3'b100, 0, 8'h88, 0);   // held message delivered
    idle(2);
    cur_tag = "R9";  step(1, 8'h37, 0, 3'b110, 0, 8'h9A, 1); idle(1);
    cur_tag = "R10";
    step(1, 8'h37, 0, 3'b111, 0, 8'h5C, 1);
    for (int i = 0; i < MAXT + 1; i++) step(0, 0, 0, 3'b000, 0, 0, 1);
    idle(2);
    cur_tag = "R11";
    for (int i = 0; i < 8; i++) step(1, 8'h37, 0, 3'(i), 0, 8'(i + 1), 0);
    idle(2);

    cur_tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      int k;
      k = $urandom_range(0, 3);
      d = (k == 0) ? local_id : (k == 1) ? 8'hFF : 8'($urandom);
      if ($urandom_range(0, 50) == 0) local_id = 8'($urandom);
      step($urandom_range(0, 1), d, $urandom_range(0, 3) == 0, 3'($urandom),
           $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 2) == 0);
    end
    idle(8);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule